// File: doc/BRIEF.md
# Exception Entry and Return Unit

This block decides, cycle by cycle, whether a simple 32-bit in-order core takes an exception, and where fetch goes next. Seven request lines are arbitrated with a fixed priority: soft reset, machine check, data access fault, instruction access fault, generic synchronous fault, external interrupt and decrementer. For the winner the block forms a vector address from a relocatable base and a fixed offset. It saves the resume address and the old machine state word into two save/restore registers. It then clears the interrupt-enable and recoverable bits of the state word and issues a one-cycle redirect.

A return-from-interrupt command copies the saved state word back and redirects fetch to the saved address. Exceptions raised while the recoverable bit is clear are promoted to machine checks. A machine check with machine-check handling disabled stops the core: the checkstop output rises and stays up until hard reset. The vector-base select bit is loaded from a configuration pin while hard reset is held, and a soft reset leaves it alone.

All outputs are registered. The redirect is a plain strobe with no back-pressure: the pipeline must act on the address in the cycle the strobe is high. Requests are sampled on every clock edge, so a request line held high is taken again in the next cycle.

Top module: `exc_vector_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the state word becomes zero except bit 2 (vector-base select), which takes `cfg_high_base_i`; both save registers clear, `checkstop_o` is 0 and `redirect_valid_o` is 0.
- R2: An exception vector is the base OR'd with an offset. The base is 0xFFF00000 when state bit 2 is 1 and 0x00000000 when it is 0. The offsets are: soft reset 0x100, machine check 0x200, data access 0x300, instruction access 0x400, external 0x500, generic fault 0x700, decrementer 0x900.
- R3: A request sampled at one clock edge produces `redirect_valid_o` high for exactly the following cycle; it is low again after the next edge unless a new event is taken.
- R4: When several requests are active together, the winner is chosen in this order: soft reset, machine check, data access, instruction access, generic fault, external, decrementer.
- R5: On exception entry `srr0_o` takes `next_pc_i` and `srr1_o` takes the state word as it stood before entry.
- R6: On exception entry state bit 4 (interrupt enable) and bit 0 (recoverable) are cleared; every other bit keeps its value.
- R7: With bit 4 at 0 the external and decrementer requests are ignored: no redirect, and the state and save registers stay unchanged. No other request is masked.
- R8: Any exception other than soft reset that is taken while bit 0 is 0 is handled as a machine check.
- R9: A machine check with state bit 3 (machine-check enable) at 0 raises `checkstop_o` instead of redirecting. From then until hard reset, no redirect is issued, and requests, returns and state writes have no effect.
- R10: Soft reset vectors to offset 0x100 whatever the value of bit 0, and keeps bit 2 unchanged.
- R11: A return (`rfi_i`) copies `srr1_o` into the state word and redirects to `srr0_o` in the next cycle. If an exception is taken in the same cycle, the exception wins and the return is dropped.
- R12: `msr_we_i` loads all 32 bits of the state word from `msr_wdata_i`, but only in a cycle with no exception, no checkstop event and no return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous hard reset, active low |
| cfg_high_base_i | input | 1 | Vector-base select, loaded during hard reset |
| soft_rst_req_i | input | 1 | Soft reset request |
| mchk_req_i | input | 1 | Machine check request |
| dacc_req_i | input | 1 | Data access fault request |
| iacc_req_i | input | 1 | Instruction access fault request |
| prog_req_i | input | 1 | Generic synchronous fault request |
| ext_req_i | input | 1 | External interrupt request (maskable) |
| dec_req_i | input | 1 | Decrementer request (maskable) |
| next_pc_i | input | 32 | Resume address saved on entry |
| rfi_i | input | 1 | Return-from-interrupt command |
| msr_we_i | input | 1 | State word write enable |
| msr_wdata_i | input | 32 | State word write data |
| msr_o | output | 32 | Current state word |
| srr0_o | output | 32 | Saved resume address |
| srr1_o | output | 32 | Saved state word |
| redirect_valid_o | output | 1 | One-cycle redirect strobe |
| redirect_addr_o | output | 32 | Redirect target |
| checkstop_o | output | 1 | Core stopped |

## Verification
The bench drives simultaneous requests and checks that the data access fault beats the external and decrementer requests. An inverted priority would vector to 0x500 or 0x900 instead. It clears the recoverable bit and raises an instruction fault, which must land on 0x200. A design that skipped the promotion would land on 0x400 and resume over an unsaved state. It checks that masked interrupts leave the state word untouched, that a soft reset with the recoverable bit clear still goes to 0x100 with the base bit kept, and that a return issued together with an exception is dropped. It also checks that a checkstop blocks every later redirect and state write, and that only a hard reset clears it. A design that let writes through after a stop would show a changed state word.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int XLEN    = 32;
  localparam int NUM_SRC = 7;
  localparam int OFF_W   = 12;

  // State word bit positions
  localparam int MSR_RI = 0;
  localparam int MSR_IP = 2;
  localparam int MSR_ME = 3;
  localparam int MSR_EE = 4;

  // Request sources, listed in priority order (index 0 wins)
  typedef enum logic [2:0] {
    SRC_SRESET = 3'd0,
    SRC_MCHK   = 3'd1,
    SRC_DACC   = 3'd2,
    SRC_IACC   = 3'd3,
    SRC_PROG   = 3'd4,
    SRC_EXT    = 3'd5,
    SRC_DEC    = 3'd6
  } src_e;

  typedef struct packed {
    logic take;   // vector to a handler
    logic stop;   // enter checkstop
    src_e src;    // handler to use when take is set
  } decision_t;

  function automatic logic [OFF_W-1:0] vec_offset(input src_e s);
    case (s)
      SRC_SRESET: vec_offset = 12'h100;
      SRC_MCHK:   vec_offset = 12'h200;
      SRC_DACC:   vec_offset = 12'h300;
      SRC_IACC:   vec_offset = 12'h400;
      SRC_EXT:    vec_offset = 12'h500;
      SRC_PROG:   vec_offset = 12'h700;
      default:    vec_offset = 12'h900;
    endcase
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               ee_i,
  input  logic               me_i,
  input  logic               ri_i,
  input  logic               halted_i,
  output decision_t          dec_o
);

  logic [NUM_SRC-1:0] eff;
  src_e               win;
  logic               any;

  // Only the external and decrementer lines obey the enable bit
  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_mask
      if (g == int'(SRC_EXT) || g == int'(SRC_DEC)) begin : g_maskable
        assign eff[g] = req_i[g] & ee_i;
      end else begin : g_fixed
        assign eff[g] = req_i[g];
      end
    end
  endgenerate

  always_comb begin
    win = SRC_DEC;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eff[i]) win = src_e'(i[2:0]);
    end
  end

  assign any = (|eff) & ~halted_i;

  always_comb begin
    dec_o = '{take: 1'b0, stop: 1'b0, src: SRC_SRESET};
    if (any) begin
      if (win == SRC_SRESET) begin
        dec_o.take = 1'b1;
        dec_o.src  = SRC_SRESET;
      end else if (win == SRC_MCHK || !ri_i) begin
        if (me_i) begin
          dec_o.take = 1'b1;
          dec_o.src  = SRC_MCHK;
        end else begin
          dec_o.stop = 1'b1;
        end
      end else begin
        dec_o.take = 1'b1;
        dec_o.src  = win;
      end
    end
  end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_pkg::*;
#(
  parameter int             AW        = XLEN,
  parameter logic [AW-1:0]  HIGH_BASE = 32'hFFF0_0000
) (
  input  logic          high_i,
  input  src_e          src_i,
  output logic [AW-1:0] addr_o
);

  localparam logic [AW-1:0] LOW_BASE = '0;

  logic [AW-1:0] base;
  assign base   = high_i ? HIGH_BASE : LOW_BASE;
  assign addr_o = base | {{(AW-OFF_W){1'b0}}, vec_offset(src_i)};

endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_pkg::*;
#(
  parameter int AW = XLEN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_high_i,
  input  decision_t     dec_i,
  input  logic [AW-1:0] vec_addr_i,
  input  logic [AW-1:0] next_pc_i,
  input  logic          rfi_i,
  input  logic          msr_we_i,
  input  logic [AW-1:0] msr_wdata_i,
  output logic [AW-1:0] msr_o,
  output logic [AW-1:0] srr0_o,
  output logic [AW-1:0] srr1_o,
  output logic          checkstop_o,
  output logic          redir_valid_o,
  output logic [AW-1:0] redir_addr_o
);

  logic [AW-1:0] entry_msr;

  always_comb begin
    entry_msr         = msr_o;
    entry_msr[MSR_EE] = 1'b0;
    entry_msr[MSR_RI] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msr_o         <= '0;
      msr_o[MSR_IP] <= cfg_high_i;
      srr0_o        <= '0;
      srr1_o        <= '0;
      checkstop_o   <= 1'b0;
      redir_valid_o <= 1'b0;
      redir_addr_o  <= '0;
    end else begin
      redir_valid_o <= 1'b0;
      if (checkstop_o) begin
        // frozen until hard reset
      end else if (dec_i.stop) begin
        checkstop_o <= 1'b1;
      end else if (dec_i.take) begin
        srr0_o        <= next_pc_i;
        srr1_o        <= msr_o;
        msr_o         <= entry_msr;
        redir_valid_o <= 1'b1;
        redir_addr_o  <= vec_addr_i;
      end else if (rfi_i) begin
        msr_o         <= srr1_o;
        redir_valid_o <= 1'b1;
        redir_addr_o  <= srr0_o;
      end else if (msr_we_i) begin
        msr_o <= msr_wdata_i;
      end
    end
  end

endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_pkg::*;
#(
  parameter int            AW        = XLEN,
  parameter logic [AW-1:0] HIGH_BASE = 32'hFFF0_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_high_base_i,
  input  logic          soft_rst_req_i,
  input  logic          mchk_req_i,
  input  logic          dacc_req_i,
  input  logic          iacc_req_i,
  input  logic          prog_req_i,
  input  logic          ext_req_i,
  input  logic          dec_req_i,
  input  logic [AW-1:0] next_pc_i,
  input  logic          rfi_i,
  input  logic          msr_we_i,
  input  logic [AW-1:0] msr_wdata_i,
  output logic [AW-1:0] msr_o,
  output logic [AW-1:0] srr0_o,
  output logic [AW-1:0] srr1_o,
  output logic          redirect_valid_o,
  output logic [AW-1:0] redirect_addr_o,
  output logic          checkstop_o
);

  logic [NUM_SRC-1:0] req_vec;
  decision_t          decision;
  logic [AW-1:0]      vec_addr;

  always_comb begin
    req_vec             = '0;
    req_vec[SRC_SRESET] = soft_rst_req_i;
    req_vec[SRC_MCHK]   = mchk_req_i;
    req_vec[SRC_DACC]   = dacc_req_i;
    req_vec[SRC_IACC]   = iacc_req_i;
    req_vec[SRC_PROG]   = prog_req_i;
    req_vec[SRC_EXT]    = ext_req_i;
    req_vec[SRC_DEC]    = dec_req_i;
  end

  exc_arbiter u_arb (
    .req_i    (req_vec),
    .ee_i     (msr_o[MSR_EE]),
    .me_i     (msr_o[MSR_ME]),
    .ri_i     (msr_o[MSR_RI]),
    .halted_i (checkstop_o),
    .dec_o    (decision)
  );

  exc_vector_gen #(.AW(AW), .HIGH_BASE(HIGH_BASE)) u_vec (
    .high_i (msr_o[MSR_IP]),
    .src_i  (decision.src),
    .addr_o (vec_addr)
  );

  exc_state_regs #(.AW(AW)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_high_i    (cfg_high_base_i),
    .dec_i         (decision),
    .vec_addr_i    (vec_addr),
    .next_pc_i     (next_pc_i),
    .rfi_i         (rfi_i),
    .msr_we_i      (msr_we_i),
    .msr_wdata_i   (msr_wdata_i),
    .msr_o         (msr_o),
    .srr0_o        (srr0_o),
    .srr1_o        (srr1_o),
    .checkstop_o   (checkstop_o),
    .redir_valid_o (redirect_valid_o),
    .redir_addr_o  (redirect_addr_o)
  );

endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk
  import exc_pkg::*;
#(
  parameter int AW = XLEN
) (
  input logic          clk,
  input logic          rst_n,
  input logic          take,
  input logic          soft_rst_req_i,
  input logic          ext_req_i,
  input logic          dec_req_i,
  input logic          mchk_req_i,
  input logic          dacc_req_i,
  input logic          iacc_req_i,
  input logic          prog_req_i,
  input logic          rfi_i,
  input logic          msr_we_i,
  input logic [AW-1:0] next_pc_i,
  input logic [AW-1:0] msr_o,
  input logic [AW-1:0] srr0_o,
  input logic [AW-1:0] srr1_o,
  input logic          redirect_valid_o,
  input logic          checkstop_o
);

  // R9: once stopped, stays stopped
  a_r9_checkstop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    checkstop_o |=> checkstop_o);

  // R9: no redirect while stopped
  a_r9_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    checkstop_o |-> !redirect_valid_o);

  // R5: save registers capture resume address and old state word
  a_r5_save_state: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !checkstop_o) |=> (srr0_o == $past(next_pc_i)) && (srr1_o == $past(msr_o)));

  // R6: entry clears enable and recoverable bits
  a_r6_entry_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !checkstop_o) |=> (!msr_o[MSR_EE] && !msr_o[MSR_RI]));

  // R7: masked interrupt alone has no effect
  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!msr_o[MSR_EE] && (ext_req_i || dec_req_i) && !soft_rst_req_i && !mchk_req_i &&
     !dacc_req_i && !iacc_req_i && !prog_req_i && !rfi_i && !msr_we_i)
    |=> (!redirect_valid_o && $stable(msr_o) && $stable(srr0_o)));

  // R10: soft reset keeps the base select bit
  a_r10_keep_base: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_req_i && !checkstop_o) |=> (msr_o[MSR_IP] == $past(msr_o[MSR_IP])));

endmodule

bind exc_vector_unit exc_vector_unit_chk #(.AW(AW)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .take             (decision.take),
  .soft_rst_req_i   (soft_rst_req_i),
  .ext_req_i        (ext_req_i),
  .dec_req_i        (dec_req_i),
  .mchk_req_i       (mchk_req_i),
  .dacc_req_i       (dacc_req_i),
  .iacc_req_i       (iacc_req_i),
  .prog_req_i       (prog_req_i),
  .rfi_i            (rfi_i),
  .msr_we_i         (msr_we_i),
  .next_pc_i        (next_pc_i),
  .msr_o            (msr_o),
  .srr0_o           (srr0_o),
  .srr1_o           (srr1_o),
  .redirect_valid_o (redirect_valid_o),
  .checkstop_o      (checkstop_o)
);

// File: tb/exc_vector_unit_tb_top.sv
module exc_vector_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg = 1'b1;
  logic        sr = 0, mc = 0, da = 0, ia = 0, pg = 0, ex = 0, dc = 0;
  logic [31:0] pc = '0;
  logic        rfi = 0, we = 0;
  logic [31:0] wd = '0;
  logic [31:0] msr, srr0, srr1, raddr;
  logic        rvalid, cstop;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  exc_vector_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_high_base_i(cfg),
    .soft_rst_req_i(sr), .mchk_req_i(mc), .dacc_req_i(da), .iacc_req_i(ia),
    .prog_req_i(pg), .ext_req_i(ex), .dec_req_i(dc), .next_pc_i(pc),
    .rfi_i(rfi), .msr_we_i(we), .msr_wdata_i(wd),
    .msr_o(msr), .srr0_o(srr0), .srr1_o(srr1),
    .redirect_valid_o(rvalid), .redirect_addr_o(raddr), .checkstop_o(cstop)
  );

  // Behavioural reference model, updated at each rising edge
  logic [31:0] m_msr = '0, m_srr0 = '0, m_srr1 = '0, m_addr = '0;
  logic        m_v = 0, m_cs = 0;

  always @(posedge clk) begin
    int off;
    logic stop;
    off  = -1;
    stop = 0;
    if (!rst_n) begin
      m_msr = {29'd0, cfg, 2'd0}; m_srr0 = 0; m_srr1 = 0; m_cs = 0; m_v = 0; m_addr = 0;
    end else begin
      m_v = 0;
      if (!m_cs) begin
        if (sr) off = 'h100;
        else if (mc || da || ia || pg || (ex && m_msr[4]) || (dc && m_msr[4])) begin
          if (mc || !m_msr[0]) begin
            if (m_msr[3]) off = 'h200; else stop = 1;
          end
          else if (da) off = 'h300;
          else if (ia) off = 'h400;
          else if (pg) off = 'h700;
          else if (ex && m_msr[4]) off = 'h500;
          else off = 'h900;
        end
        if (stop) m_cs = 1;
        else if (off >= 0) begin
          m_srr0 = pc; m_srr1 = m_msr;
          m_msr[4] = 0; m_msr[0] = 0;
          m_v = 1;
          m_addr = (m_srr1[2] ? 32'hFFF0_0000 : 32'h0) + off;
        end else if (rfi) begin
          m_msr = m_srr1; m_v = 1; m_addr = m_srr0;
        end else if (we) m_msr = wd;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 model msr", msr, m_msr);
      chk("R5 model srr0", srr0, m_srr0);
      chk("R5 model srr1", srr1, m_srr1);
      chk("R3 model valid", {31'd0, rvalid}, {31'd0, m_v});
      if (m_v) chk("R2 model addr", raddr, m_addr);
      chk("R9 model checkstop", {31'd0, cstop}, {31'd0, m_cs});
    end
  end

  task automatic idle_inputs;
    sr = 0; mc = 0; da = 0; ia = 0; pg = 0; ex = 0; dc = 0; rfi = 0; we = 0;
  endtask

  // apply current inputs for one edge, then clear them
  task automatic step;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic wr_msr(input logic [31:0] v);
    we = 1; wd = v; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state with base select from configuration pin
    chk("R1 msr", msr, 32'h4);
    chk("R1 srr0", srr0, 0);
    chk("R1 checkstop", {31'd0, cstop}, 0);
    chk("R1 valid", {31'd0, rvalid}, 0);

    wr_msr(32'h1D);
    chk("R12 msr write", msr, 32'h1D);

    ex = 1; pc = 32'h1000; step();
    chk("R2 ext vector", raddr, 32'hFFF0_0500);
    chk("R3 valid", {31'd0, rvalid}, 1);
    chk("R5 srr0", srr0, 32'h1000);
    chk("R5 srr1", srr1, 32'h1D);
    chk("R6 msr", msr, 32'h0C);
    step();
    chk("R3 pulse ends", {31'd0, rvalid}, 0);

    ex = 1; dc = 1; step();
    chk("R7 masked valid", {31'd0, rvalid}, 0);
    chk("R7 masked msr", msr, 32'h0C);

    rfi = 1; step();
    chk("R11 rfi msr", msr, 32'h1D);
    chk("R11 rfi addr", raddr, 32'h1000);

    da = 1; ex = 1; dc = 1; pc = 32'h2000; step();
    chk("R4 priority", raddr, 32'hFFF0_0300);
    rfi = 1; step();

    wr_msr(32'h1C);
    ia = 1; pc = 32'h3000; step();
    chk("R8 promoted", raddr, 32'hFFF0_0200);
    chk("R8 srr1", srr1, 32'h1C);

    wr_msr(32'h1D);
    pg = 1; step();
    chk("R2 generic fault", raddr, 32'hFFF0_0700);

    wr_msr(32'h19);
    dc = 1; step();
    chk("R2 low base dec", raddr, 32'h0000_0900);

    wr_msr(32'h1C);
    sr = 1; pc = 32'h4000; step();
    chk("R10 soft reset vec", raddr, 32'hFFF0_0100);
    chk("R10 base kept", msr, 32'h0C);

    rfi = 1; we = 1; wd = 32'h0; step();
    chk("R12 rfi beats write", msr, 32'h1C);

    wr_msr(32'h15);
    mc = 1; step();
    chk("R9 checkstop", {31'd0, cstop}, 1);
    chk("R9 no redirect", {31'd0, rvalid}, 0);
    da = 1; rfi = 1; we = 1; wd = 32'h0; step();
    chk("R9 frozen msr", msr, 32'h15);
    chk("R9 frozen valid", {31'd0, rvalid}, 0);

    cfg = 0; rst_n = 0; step(); step();
    rst_n = 1;
    @(negedge clk);
    chk("R1 hard reset clears", {31'd0, cstop}, 0);
    chk("R1 base from cfg", msr, 32'h0);

    wr_msr(32'h19);
    ia = 1; rfi = 1; pc = 32'h5000; step();
    chk("R11 exception wins", raddr, 32'h0000_0400);
    chk("R11 srr1", srr1, 32'h19);
    step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule